// File: doc/BRIEF.md
# Multi-Lane Serial ADC Sample Capture

This block receives serial ADC bit streams from a radar front end on several parallel lanes. All lanes share one bit clock, a frame strobe and a data-valid strobe. Each lane's bits are packed into parallel samples, most significant bit first. At each sample, the block emits one word per lane together with a sample index counted from the start of the chirp and the current chirp index. The bit clock drives `clk_i` directly, so each rising edge carries one bit per lane.

Sample boundaries are taken from the rising edge of the frame strobe, not from a free-running bit count. If a bit is lost or an extra bit appears, the next frame edge restores the alignment, so no error lasts beyond one sample. Each rising edge of data-valid starts a new chirp from sample zero. When data-valid falls, the number of completed samples is compared with the configured chirp length, and the result is kept as a flag until the next chirp starts. The block counts chirps within a frame and pulses a done output after the last one. A realign input, or the reset, zeroes all counters and disarms capture until data-valid rises again.

Top module: `adc_lane_capture`

## Requirements
- R1: Each of the LANES lanes carries a sample of SAMPLE_W bits, most significant bit first. The word from lane l appears at `out_data_o[l*SAMPLE_W +: SAMPLE_W]`.
- R2: Bits are taken only while `valid_i` is high and capture is armed. `out_valid_o` is high for exactly one cycle, in the cycle after the last bit of a sample, and never when `valid_i` was low in the previous cycle.
- R3: A rising edge of `valid_i` starts a chirp. The bit on that edge is the first bit of sample index 0. Any partial sample left from the previous chirp is discarded.
- R4: A rising edge of `frame_i` that arrives while the bit position is not at a sample boundary does three things: the partial bits are discarded, that bit becomes bit one of a new sample, and `resync_cnt_o` increments, saturating at its maximum.
- R5: `out_sample_idx_o` counts up by one for each sample emitted within a chirp. The sample index is not advanced by discarded partial samples.
- R6: When `valid_i` falls, `len_err_o` becomes 1 if the number of completed samples differs from SAMPLES, and 0 otherwise, one cycle after the falling edge. It holds that value until the next chirp starts, where it is cleared.
- R7: `out_chirp_idx_o` gives the index of the chirp in progress within its frame. It advances one cycle after each falling edge of `valid_i`. After chirp CHIRPS-1 it wraps to 0, and `frame_done_o` pulses high for exactly one cycle at the same time.
- R8: Reset, or `realign_i` held high for a cycle, zeroes the sample, chirp and resync counters and disarms capture. Bits are then ignored until the next rising edge of `valid_i`; `valid_i` that is already high when reset is released does not count as a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, one bit per lane per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| realign_i | input | 1 | Zero counters and wait for next valid rise |
| valid_i | input | 1 | Data-valid strobe, high during a chirp's transfer |
| frame_i | input | 1 | Frame strobe, rising edge on the first bit of a sample |
| lane_i | input | LANES | One serial bit per lane |
| out_valid_o | output | 1 | One-cycle strobe for a completed sample set |
| out_data_o | output | LANES*SAMPLE_W | Assembled words, lane 0 in the low bits |
| out_sample_idx_o | output | $clog2(SAMPLES)+1 | Sample index within the chirp |
| out_chirp_idx_o | output | CH_W | Chirp index within the frame |
| len_err_o | output | 1 | Chirp length mismatch flag |
| frame_done_o | output | 1 | Pulse after the last chirp of a frame |
| resync_cnt_o | output | RSYNC_W | Saturating count of misaligned frame edges |

## Verification
The bench uses a small configuration: 4 lanes, 4-bit samples, 6 samples per chirp and 3 chirps per frame. It sweeps a short partial sample of 2 or 3 bits across every sample position, and inserts single extra bits between samples. A design that counted bits without checking the frame edge would emit shifted words from then on. A design that kept the partial bits would corrupt the next word or skip an index. Short chirps, long chirps and chirps that end mid-sample check that the length flag compares completed samples only and is cleared at the next start. A realign during a chirp, and valid already high when reset is released, both check that no word escapes before a genuine rising edge of valid.

// File: rtl/adc_cap_pkg.sv
package adc_cap_pkg;
  typedef struct packed {
    logic start;      // chirp start, first bit of sample 0
    logic load;       // restart assembly with current bit
    logic shift;      // consume current bit
    logic done;       // current bit completes a sample
    logic chirp_end;  // valid fell while armed
    logic resync;     // misaligned frame edge
  } frm_ctl_t;
endpackage

// File: rtl/adc_bit_framer.sv
module adc_bit_framer
  import adc_cap_pkg::*;
#(
  parameter int SAMPLE_W = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     realign_i,
  input  logic     valid_i,
  input  logic     frame_i,
  output frm_ctl_t ctl_o
);
  localparam int BW = (SAMPLE_W > 2) ? $clog2(SAMPLE_W) : 1;
  localparam logic [BW-1:0] LAST = BW'(SAMPLE_W - 1);

  logic          valid_q, frame_q, armed_q;
  logic [BW-1:0] bit_cnt_q;
  logic          rise, fall, fedge, run;

  assign rise  = valid_i & ~valid_q;
  assign fall  = ~valid_i & valid_q;
  assign fedge = frame_i & ~frame_q;
  assign run   = armed_q & valid_i & ~rise & ~realign_i;

  always_comb begin
    ctl_o.start     = rise & ~realign_i;
    ctl_o.resync    = run & fedge & (bit_cnt_q != '0);
    ctl_o.load      = ctl_o.start | ctl_o.resync;
    ctl_o.shift     = run | ctl_o.start;
    ctl_o.done      = run & ~ctl_o.resync & (bit_cnt_q == LAST);
    ctl_o.chirp_end = armed_q & fall & ~realign_i;
  end

  // valid_q resets high: a strobe already high at reset release is no edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b1;
      frame_q   <= 1'b0;
      armed_q   <= 1'b0;
      bit_cnt_q <= '0;
    end else begin
      valid_q <= valid_i;
      frame_q <= frame_i;
      if (realign_i) begin
        armed_q   <= 1'b0;
        bit_cnt_q <= '0;
      end else if (ctl_o.load) begin
        armed_q   <= armed_q | ctl_o.start;
        bit_cnt_q <= BW'(1);
      end else if (run) begin
        bit_cnt_q <= (bit_cnt_q == LAST) ? '0 : bit_cnt_q + BW'(1);
      end
    end
  end
endmodule

// File: rtl/adc_lane_shift.sv
module adc_lane_shift #(
  parameter int SAMPLE_W = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                load_i,
  input  logic                shift_i,
  input  logic                bit_i,
  output logic [SAMPLE_W-1:0] word_o
);
  logic [SAMPLE_W-1:0] sh_q;

  assign word_o = {sh_q[SAMPLE_W-2:0], bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sh_q <= '0;
    else if (load_i)  sh_q <= SAMPLE_W'(bit_i);
    else if (shift_i) sh_q <= word_o;
  end
endmodule

// File: rtl/adc_chirp_track.sv
module adc_chirp_track
  import adc_cap_pkg::*;
#(
  parameter int SAMPLES = 512,
  parameter int CHIRPS  = 8,
  parameter int IDX_W   = 10,
  parameter int CH_W    = 3,
  parameter int RSYNC_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               realign_i,
  input  frm_ctl_t           ctl_i,
  output logic [IDX_W-1:0]   sample_cnt_o,
  output logic [CH_W-1:0]    chirp_idx_o,
  output logic               len_err_o,
  output logic               frame_done_o,
  output logic [RSYNC_W-1:0] resync_cnt_o
);
  localparam logic [IDX_W-1:0] N_SMP   = IDX_W'(SAMPLES);
  localparam logic [CH_W-1:0]  LAST_CH = CH_W'(CHIRPS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sample_cnt_o <= '0;
      chirp_idx_o  <= '0;
      len_err_o    <= 1'b0;
      frame_done_o <= 1'b0;
      resync_cnt_o <= '0;
    end else begin
      frame_done_o <= 1'b0;
      if (realign_i) begin
        sample_cnt_o <= '0;
        chirp_idx_o  <= '0;
        resync_cnt_o <= '0;
      end else begin
        if (ctl_i.start) begin
          sample_cnt_o <= '0;
          len_err_o    <= 1'b0;
        end else if (ctl_i.done && (sample_cnt_o != '1)) begin
          sample_cnt_o <= sample_cnt_o + IDX_W'(1);
        end
        if (ctl_i.resync && (resync_cnt_o != '1))
          resync_cnt_o <= resync_cnt_o + RSYNC_W'(1);
        if (ctl_i.chirp_end) begin
          len_err_o <= (sample_cnt_o != N_SMP);
          if (chirp_idx_o == LAST_CH) begin
            chirp_idx_o  <= '0;
            frame_done_o <= 1'b1;
          end else begin
            chirp_idx_o <= chirp_idx_o + CH_W'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_lane_capture.sv
module adc_lane_capture
  import adc_cap_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 16,
  parameter int SAMPLES  = 512,
  parameter int CHIRPS   = 8,
  parameter int RSYNC_W  = 8,
  localparam int IDX_W   = $clog2(SAMPLES) + 1,
  localparam int CH_W    = (CHIRPS > 1) ? $clog2(CHIRPS) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      realign_i,
  input  logic                      valid_i,
  input  logic                      frame_i,
  input  logic [LANES-1:0]          lane_i,
  output logic                      out_valid_o,
  output logic [LANES*SAMPLE_W-1:0] out_data_o,
  output logic [IDX_W-1:0]          out_sample_idx_o,
  output logic [CH_W-1:0]           out_chirp_idx_o,
  output logic                      len_err_o,
  output logic                      frame_done_o,
  output logic [RSYNC_W-1:0]        resync_cnt_o
);
  frm_ctl_t                  ctl;
  logic [LANES*SAMPLE_W-1:0] words;
  logic [IDX_W-1:0]          sample_cnt;

  adc_bit_framer #(.SAMPLE_W(SAMPLE_W)) u_framer (
    .clk_i, .rst_ni, .realign_i, .valid_i, .frame_i, .ctl_o(ctl)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    adc_lane_shift #(.SAMPLE_W(SAMPLE_W)) u_shift (
      .clk_i, .rst_ni,
      .load_i (ctl.load),
      .shift_i(ctl.shift),
      .bit_i  (lane_i[l]),
      .word_o (words[l*SAMPLE_W +: SAMPLE_W])
    );
  end

  adc_chirp_track #(
    .SAMPLES(SAMPLES), .CHIRPS(CHIRPS), .IDX_W(IDX_W), .CH_W(CH_W), .RSYNC_W(RSYNC_W)
  ) u_track (
    .clk_i, .rst_ni, .realign_i,
    .ctl_i       (ctl),
    .sample_cnt_o(sample_cnt),
    .chirp_idx_o (out_chirp_idx_o),
    .len_err_o,
    .frame_done_o,
    .resync_cnt_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o      <= 1'b0;
      out_data_o       <= '0;
      out_sample_idx_o <= '0;
    end else begin
      out_valid_o <= ctl.done;
      if (ctl.done) begin
        out_data_o       <= words;
        out_sample_idx_o <= sample_cnt;
      end
    end
  end
endmodule

// File: rtl/adc_lane_capture_sva.sv
module adc_lane_capture_sva #(
  parameter int CH_W    = 3,
  parameter int RSYNC_W = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               realign_i,
  input logic               valid_i,
  input logic               out_valid_o,
  input logic [CH_W-1:0]    out_chirp_idx_o,
  input logic               len_err_o,
  input logic               frame_done_o,
  input logic [RSYNC_W-1:0] resync_cnt_o
);
  a_r2_no_output_in_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(valid_i) |-> !out_valid_o);

  a_r2_single_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |=> !out_valid_o);

  a_r7_done_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o);

  a_r7_done_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |-> (!$past(valid_i) && $past(valid_i, 2) && out_chirp_idx_o == '0));

  a_r6_flag_held_in_chirp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && $past(valid_i) && $past(valid_i, 2)) |-> $stable(len_err_o));

  a_r4_resync_monotonic: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(realign_i) |-> (resync_cnt_o >= $past(resync_cnt_o)));

  a_r8_realign_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(realign_i) |-> (!out_valid_o && out_chirp_idx_o == '0 && resync_cnt_o == '0));
endmodule

bind adc_lane_capture adc_lane_capture_sva #(.CH_W(CH_W), .RSYNC_W(RSYNC_W)) u_sva (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .realign_i      (realign_i),
  .valid_i        (valid_i),
  .out_valid_o    (out_valid_o),
  .out_chirp_idx_o(out_chirp_idx_o),
  .len_err_o      (len_err_o),
  .frame_done_o   (frame_done_o),
  .resync_cnt_o   (resync_cnt_o)
);

// File: tb/adc_lane_capture_tb.sv
module adc_lane_capture_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int L  = 4;
  localparam int W  = 4;
  localparam int S  = 6;
  localparam int C  = 3;
  localparam int RW = 4;
  localparam int IW = $clog2(S) + 1;
  localparam int CW = $clog2(C);
  localparam int EW = CW + IW + L*W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          realign = 1'b0, valid = 1'b0, frame = 1'b0;
  logic [L-1:0]  lanes = '0;
  logic          out_valid, len_err, frame_done;
  logic [L*W-1:0] out_data;
  logic [IW-1:0] out_idx;
  logic [CW-1:0] out_ch;
  logic [RW-1:0] rs_cnt;

  int checks = 0, fails = 0;
  int g = 0, cur_chirp = 0, exp_rs = 0;
  bit monitor_on = 1'b0, finished = 1'b0;
  logic [EW-1:0] expq[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_lane_capture #(.LANES(L), .SAMPLE_W(W), .SAMPLES(S), .CHIRPS(C), .RSYNC_W(RW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .realign_i(realign), .valid_i(valid), .frame_i(frame),
    .lane_i(lanes), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_sample_idx_o(out_idx), .out_chirp_idx_o(out_ch), .len_err_o(len_err),
    .frame_done_o(frame_done), .resync_cnt_o(rs_cnt)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] sval(input int n, input int l);
    return W'((n*5 + l*3 + 1) % (1 << W));
  endfunction

  task automatic drive(input logic v, input logic f, input logic [L-1:0] b, input logic r = 1'b0);
    @(negedge clk);
    valid = v; frame = f; lanes = b; realign = r;
  endtask

  task automatic send_sample(input int idx, input bit push);
    logic [L*W-1:0] d;
    for (int l = 0; l < L; l++) d[l*W +: W] = sval(g, l);
    for (int b = W-1; b >= 0; b--) begin
      logic [L-1:0] bits;
      for (int l = 0; l < L; l++) bits[l] = d[l*W + b];
      drive(1'b1, b == W-1, bits);
    end
    if (push) expq.push_back({CW'(cur_chirp), IW'(idx), d});
    g++;
  endtask

  task automatic partial(input int k);
    for (int b = 0; b < k; b++) drive(1'b1, b == 0, L'(b + 5));
  endtask

  task automatic end_chirp(input bit armed, input bit exp_err);
    bit fd;
    fd = armed && (cur_chirp == C-1);
    drive(1'b0, 1'b0, '0);
    @(posedge clk); #1;
    chk(frame_done == fd, "R7 frame_done after fall", frame_done, fd);
    chk(len_err == exp_err, "R6 len_err after fall", len_err, exp_err);
    if (armed) cur_chirp = fd ? 0 : cur_chirp + 1;
    chk(out_ch == CW'(cur_chirp), "R7 chirp index", out_ch, cur_chirp);
    chk(rs_cnt == RW'(exp_rs), "R4 resync count", rs_cnt, exp_rs);
    drive(1'b0, 1'b0, '0);
    drive(1'b0, 1'b0, '0);
    chk(frame_done == 1'b0, "R7 frame_done one cycle", frame_done, 0);
    chk(len_err == exp_err, "R6 len_err held in gap", len_err, exp_err);
  endtask

  // n samples; partial of pk bits before sample pat; extra bit after sample xat; tail bits at end
  task automatic run_chirp(input int n, input int pat = -1, input int pk = 0,
                           input int xat = -1, input int tail = 0);
    for (int s = 0; s < n; s++) begin
      if (s == pat) begin partial(pk); exp_rs++; end
      send_sample(s, 1'b1);
      if (s == 0) chk(len_err == 1'b0, "R6 len_err cleared at start", len_err, 0);
      if (s == xat) begin
        drive(1'b1, 1'b0, '1);
        if (s + 1 < n) exp_rs++;
      end
    end
    if (tail > 0) partial(tail);
    end_chirp(1'b1, n != S);
  endtask

  always @(posedge clk) begin
    #1;
    if (monitor_on && rst_n && out_valid) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R2 unexpected output strobe", 1, 0);
      end else begin
        logic [EW-1:0] e;
        e = expq.pop_front();
        chk(out_data == e[L*W-1:0], "R1 lane words", out_data, e[L*W-1:0]);
        chk(out_idx == e[L*W +: IW], "R5 R3 sample index", out_idx, e[L*W +: IW]);
        chk(out_ch == e[EW-1 -: CW], "R7 chirp index on output", out_ch, e[EW-1 -: CW]);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    valid = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    monitor_on = 1'b1;
    @(negedge clk);
    chk(out_valid == 0 && out_data == '0 && out_idx == '0, "R8 reset outputs", out_data, 0);
    chk(out_ch == '0 && rs_cnt == '0 && !len_err && !frame_done, "R8 reset state", out_ch, 0);
    // valid high through reset: no rising edge, bits ignored (R8)
    for (int s = 0; s < 2; s++) send_sample(s, 1'b0);
    end_chirp(1'b0, 1'b0);
    chk(expq.size() == 0, "R8 nothing before valid rise", expq.size(), 0);

    // two full frames (R1 R5 R7)
    for (int c = 0; c < 2*C; c++) run_chirp(S);

    // length errors (R6)
    run_chirp(S-1);
    run_chirp(S+1);
    run_chirp(S);
    run_chirp(S, -1, 0, -1, 2);   // partial tail discarded (R3)
    run_chirp(S, -1, 0, -1, 3);
    run_chirp(S);

    // misaligned frame edges swept over sample positions (R4)
    for (int p = 1; p < S; p++) run_chirp(S, p, 2 + (p % 2));
    run_chirp(S, -1, 0, 2);
    run_chirp(S, -1, 0, 0);

    // realign mid-chirp (R8)
    send_sample(0, 1'b1);
    send_sample(1, 1'b1);
    drive(1'b1, 1'b1, '0, 1'b1);
    @(posedge clk); #1;
    chk(out_ch == '0, "R8 realign clears chirp index", out_ch, 0);
    chk(rs_cnt == '0, "R8 realign clears resync count", rs_cnt, 0);
    cur_chirp = 0; exp_rs = 0;
    drive(1'b1, 1'b0, '0, 1'b0);
    drive(1'b1, 1'b0, '0);
    for (int s = 0; s < 3; s++) send_sample(s, 1'b0);
    end_chirp(1'b0, 1'b0);
    chk(expq.size() == 0, "R8 no output after realign", expq.size(), 0);
    for (int c = 0; c < C; c++) run_chirp(S);

    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R2 all expected samples emitted", expq.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule